// File: doc/BRIEF.md
# Byte Shuffle Unit

The block builds one 32-bit word from bytes picked out of two 32-bit operands. The operands are joined into an eight-byte pool. The second operand supplies the upper four bytes and the first operand the lower four. Each of the four result lanes names one pool byte. A lane can also turn its byte into a fill made of copies of that byte's top bit. This gives sign extension of a selected byte in the same step as the move.

A 3-bit mode input picks how the lane choices are formed. In generic mode the low 16 selector bits are four 4-bit lane codes, used as given. The other six modes rebuild all four lane codes from the two lowest selector bits alone. These modes cover:

- a forward funnel and a backward funnel,
- replication of one byte,
- clamping toward the left edge and toward the right edge,
- replication of one half-word.

An operation is accepted when in_valid is high. Its result appears one clock later, together with out_valid.

Top module: `byte_shuffle_unit`

## Requirements
- R1: In generic mode (mode 0), result lane i (bits 8i+7..8i) takes pool byte sel[4i+2:4i]. Pool bytes 0..3 are op_a bytes 0..3, with byte 0 being op_a[7:0]. Pool bytes 4..7 are op_b bytes 0..3.
- R2: In generic mode, when sel[4i+3] is 1, lane i becomes eight copies of bit 7 of its chosen pool byte. When that bit is 0, the byte passes unchanged.
- R3: In modes 1 to 6 only sel[1:0] (called V) is used, and sel[31:2] has no effect. Mode 7 behaves exactly like mode 0. In modes 1 to 6 no lane applies a sign fill.
- R4: Mode 1 (forward) picks pool bytes V, V+1, V+2, V+3 for lanes 0 to 3.
- R5: Mode 2 (backward) picks pool bytes V, (V-1) mod 8, (V-2) mod 8, (V-3) mod 8 for lanes 0 to 3.
- R6: Mode 3 (replicate byte) picks pool byte V for all four lanes.
- R7: Mode 4 (clamp left) picks pool bytes V, max(V,1), max(V,2), 3 for lanes 0 to 3.
- R8: Mode 5 (clamp right) picks pool bytes 0, min(V,1), min(V,2), V for lanes 0 to 3.
- R9: Mode 6 (replicate half-word) sets W = 2*V[0] and picks pool bytes W, W+1, W, W+1 for lanes 0 to 3.
- R10: out_valid is in_valid delayed by one clock. The result of an operation accepted at one edge is on result after that edge.
- R11: While in_valid is low, result holds its last value whatever the other inputs do.
- R12: A synchronous active-high rst clears out_valid and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op_a | input | 32 | Operand supplying pool bytes 0..3 |
| op_b | input | 32 | Operand supplying pool bytes 4..7 |
| sel | input | 32 | Lane selector codes |
| mode | input | 3 | Lane code construction mode |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered shuffled word |

## Verification
The assertions check the following on every cycle:
- the one-clock valid delay and the reset clearing;
- holding of the result while idle;
- the structural signatures of several modes: four equal bytes in replicate-byte mode, equal halves in half-word mode, a fixed top lane in clamp-left mode, and a byte of all zeros or all ones where the generic sign fill is requested.

The exact byte chosen for each lane in every mode, the modular wrap of the backward funnel, and the independence from the upper selector bits can only be shown by the bench's scenarios. Those scenarios compare the result against an independently computed lane model, sweeping V in every mode over random operands.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int POOL_BYTES = 2 * LANES;
  localparam int IDX_W  = $clog2(POOL_BYTES);
  localparam int CODE_W = IDX_W + 1;
  localparam int V_W    = $clog2(LANES);

  typedef enum logic [2:0] {
    MODE_GENERIC = 3'd0,
    MODE_FWD     = 3'd1,
    MODE_BWD     = 3'd2,
    MODE_REP     = 3'd3,
    MODE_CLAMP_L = 3'd4,
    MODE_CLAMP_R = 3'd5,
    MODE_HALF    = 3'd6,
    MODE_ALT     = 3'd7
  } permMode_e;

  typedef struct packed {
    logic                            capture;
    logic [LANES-1:0]                fillSign;
    logic [LANES-1:0][IDX_W-1:0]     laneIdx;
  } laneCtrl_t;
endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] sel,
  input  logic [2:0]        mode,
  output laneCtrl_t         ctrl,
  output logic              outValid
);
  logic [V_W-1:0]   v;
  logic [IDX_W-1:0] vx;
  permMode_e        modeE;

  assign v     = sel[V_W-1:0];
  assign vx    = IDX_W'(v);
  assign modeE = permMode_e'(mode);

  assign ctrl.capture = inValid;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [IDX_W-1:0] LANE_I = IDX_W'(i);
    logic [CODE_W-1:0] rawCode;
    assign rawCode = sel[CODE_W*i +: CODE_W];

    always_comb begin
      ctrl.fillSign[i] = 1'b0;
      unique case (modeE)
        MODE_FWD:     ctrl.laneIdx[i] = vx + LANE_I;
        MODE_BWD:     ctrl.laneIdx[i] = vx - LANE_I;
        MODE_REP:     ctrl.laneIdx[i] = vx;
        MODE_CLAMP_L: ctrl.laneIdx[i] = (vx > LANE_I) ? vx : LANE_I;
        MODE_CLAMP_R: ctrl.laneIdx[i] = (vx < LANE_I) ? vx : LANE_I;
        MODE_HALF:    ctrl.laneIdx[i] = {1'b0, v[0], LANE_I[0]};
        default: begin
          ctrl.laneIdx[i]  = rawCode[IDX_W-1:0];
          ctrl.fillSign[i] = rawCode[CODE_W-1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  laneCtrl_t         ctrl,
  output logic [WORD_W-1:0] result
);
  logic [2*WORD_W-1:0] pool;
  logic [WORD_W-1:0]   nextWord;

  assign pool = {opB, opA};

  for (genvar i = 0; i < LANES; i++) begin : g_mux
    logic [BYTE_W-1:0] picked;
    assign picked = pool[BYTE_W*ctrl.laneIdx[i] +: BYTE_W];
    assign nextWord[BYTE_W*i +: BYTE_W] =
      ctrl.fillSign[i] ? {BYTE_W{picked[BYTE_W-1]}} : picked;
  end

  always_ff @(posedge clk) begin
    if (rst)               result <= '0;
    else if (ctrl.capture) result <= nextWord;
  end
endmodule

// File: rtl/byte_shuffle_unit.sv
module byte_shuffle_unit
  import bsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [31:0] sel,
  input  logic [2:0]  mode,
  output logic        out_valid,
  output logic [31:0] result
);
  laneCtrl_t laneCtrl;

  bsu_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (in_valid),
    .sel      (sel),
    .mode     (mode),
    .ctrl     (laneCtrl),
    .outValid (out_valid)
  );

  bsu_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .opA    (op_a),
    .opB    (op_b),
    .ctrl   (laneCtrl),
    .result (result)
  );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] sel,
  input logic [2:0]  mode,
  input logic        out_valid,
  input logic [31:0] result
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && result == 32'd0)); // R12

  AST_VALID_RISES: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R11

  AST_REP_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd3) |=>
      (result[7:0] == result[15:8] && result[15:8] == result[23:16]
       && result[23:16] == result[31:24])); // R6

  AST_HALF_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd6) |=> (result[31:16] == result[15:0])); // R9

  AST_CLAMPL_TOP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd4) |=> (result[31:24] == $past(op_a[31:24]))); // R7

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 3'd0 && sel[3]) |=>
      (result[7:0] == 8'h00 || result[7:0] == 8'hFF)); // R2
endmodule

bind byte_shuffle_unit bsu_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .sel       (sel),
  .mode      (mode),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/byte_shuffle_unit_tb.sv
module byte_shuffle_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] op_a, op_b, sel;
  logic [2:0]  mode;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  byte_shuffle_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sel(sel), .mode(mode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [7:0] poolByte(input logic [31:0] a, input logic [31:0] b,
                                          input int k);
    logic [63:0] p;
    p = {b, a};
    return p[8*k +: 8];
  endfunction

  function automatic logic [31:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] s, input logic [2:0] m);
    logic [31:0] r;
    int vv, pick, fill;
    logic [7:0] by;
    vv = int'(s[1:0]);
    r = 0;
    for (int ln = 0; ln < 4; ln++) begin
      fill = 0;
      case (m)
        3'd1: pick = (vv + ln) % 8;
        3'd2: pick = (vv - ln + 8) % 8;
        3'd3: pick = vv;
        3'd4: pick = (ln == 3) ? 3 : ((vv > ln) ? vv : ln);
        3'd5: pick = (ln == 0) ? 0 : ((ln == 3) ? vv : ((vv < ln) ? vv : ln));
        3'd6: pick = 2 * (vv % 2) + (ln % 2);
        default: begin
          pick = int'(s[4*ln +: 3]);
          fill = int'(s[4*ln+3]);
        end
      endcase
      by = poolByte(a, b, pick);
      if (fill != 0) by = by[7] ? 8'hFF : 8'h00;
      r[8*ln +: 8] = by;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] s, input logic [2:0] m);
    @(negedge clk);
    op_a = a; op_b = b; sel = s; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
    check(req, result, refModel(a, b, s, m));
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    logic [31:0] held, r1, r2, ra, rb;
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    rst = 1'b1; in_valid = 1'b0; op_a = 0; op_b = 0; sel = 0; mode = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset result", result, 32'd0);
    check("R12 reset out_valid", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;

    // R1 directed identity and full swap
    runOp("R1 identity", 32'h44332211, 32'h88776655, 32'h00003210, 3'd0);
    runOp("R1 take B", 32'h44332211, 32'h88776655, 32'h00007654, 3'd0);
    // R2 sign fill on negative and positive bytes
    runOp("R2 sign fill", 32'h7F80FF01, 32'h00000000, 32'h00009A8B, 3'd0);
    // R3 mode 7 equals generic
    runOp("R3 mode7", 32'hDEADBEEF, 32'hCAFEF00D, 32'h0000B7A5, 3'd7);
    // R5 backward wrap with V=0
    runOp("R5 bwd wrap", 32'h44332211, 32'h88776655, 32'h00000000, 3'd2);

    // R1 R2 random generic selectors
    for (int n = 0; n < 200; n++)
      runOp("R1 R2 generic random", $urandom, $urandom, $urandom, 3'd0);

    // R4..R9 every V in every compact mode, random upper selector bits
    for (int m = 1; m <= 6; m++) begin
      for (int vv = 0; vv < 4; vv++) begin
        for (int n = 0; n < 8; n++) begin
          string tag;
          case (m)
            1: tag = "R4 forward";
            2: tag = "R5 backward";
            3: tag = "R6 replicate";
            4: tag = "R7 clamp left";
            5: tag = "R8 clamp right";
            default: tag = "R9 half";
          endcase
          runOp(tag, $urandom, $urandom, {$urandom} & 32'hFFFF_FFFC | vv, 3'(m));
        end
      end
    end

    // R3 upper selector bits ignored in compact modes
    for (int m = 1; m <= 6; m++) begin
      ra = $urandom; rb = $urandom;
      runOp("R3 upper low", ra, rb, 32'h00000002, 3'(m));
      r1 = result;
      runOp("R3 upper high", ra, rb, 32'hFFFFFFFE, 3'(m));
      r2 = result;
      check("R3 upper ignored", r2, r1);
    end

    // R11 hold while idle with changing inputs
    runOp("R11 setup", 32'h01234567, 32'h89ABCDEF, 32'h00001032, 3'd0);
    held = result;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      op_a = $urandom; op_b = $urandom; sel = $urandom; mode = 3'($urandom);
      check("R11 idle hold", result, held);
      check("R10 idle out_valid", {31'd0, out_valid}, 32'd0);
    end

    // R12 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12 reset mid-run", result, 32'd0);
    check("R12 reset mid-run valid", {31'd0, out_valid}, 32'd0);

    finishRun();
  end
endmodule